// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a simple request port and a four-bank SDRAM. It drives the command pins (chip select, RAS, CAS, WE), the two bank-select bits and the twelve address lines. It brings the memory up after reset and then serves one read or write at a time. Each access opens a row, issues the column command and closes the row again (a closed-page policy). A timer inserts auto refresh at a fixed average interval.

All minimum spacings between commands are given in picoseconds. At elaboration they are turned into clock counts from the clock-period parameter `T_CK_PS`, by rounding up. The same RTL therefore fits a 7.5 ns or a 10 ns clock with no hand-tuned counts.

Command encodings on {cs_n, ras_n, cas_n, we_n} are:

| Command | Encoding |
|---|---|
| NOP | 0111 |
| ACTIVE | 0011 |
| READ | 0101 |
| WRITE | 0100 |
| PRECHARGE | 0010 |
| AUTO REFRESH | 0001 |
| MODE REGISTER SET | 0000 |

In this document, "ceil(x)" means x picoseconds divided by `T_CK_PS` and rounded up, with a minimum of 1.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the command pins show NOP (0111), `ready` is low and `busy` is high.
- R2: No command other than NOP appears until ceil(100 us) clocks after reset release. The first command is PRECHARGE (0010) with A10 high, meaning all banks, and it appears exactly at that count.
- R3: Initialisation runs in this order: PRECHARGE ALL, then `INIT_REFS` AUTO REFRESH commands (0001), then MODE REGISTER SET (0000). The MODE REGISTER SET has BA = 0 and A = CAS latency in A6..A4, with all other bits zero (burst length 1, sequential). `ready` rises 2 clocks after the MODE REGISTER SET, and no request is acknowledged before that.
- R4: An ACTIVE (0011) carries the request's bank on BA and its row on A11..A0. The READ (0101) or WRITE (0100) follows exactly ceil(20 ns) clocks later, with the same bank, the column on A9..A0 and A11..A10 low.
- R5: The access ends with a PRECHARGE of that bank only (A10 low, same BA). It is issued max(ceil(45 ns) - ceil(20 ns), 1) clocks after a READ. After a WRITE it is issued max of that value and ceil(8 ns) clocks later.
- R6: An ACTIVE or AUTO REFRESH comes at least ceil(20 ns) clocks after the last PRECHARGE.
- R7: Any two commands from the set {ACTIVE, AUTO REFRESH} are at least ceil(67.5 ns) clocks apart.
- R8: After a MODE REGISTER SET, at least 2 clocks pass before any other command.
- R9: Once `ready` is high, and with no traffic, an AUTO REFRESH occurs every floor(15625 ns / `T_CK_PS`) clocks. Each one is preceded by a PRECHARGE ALL.
- R10: While a refresh is pending or in progress, `busy` is high and a waiting request is not acknowledged. The request's ACTIVE follows the AUTO REFRESH.
- R11: `req_ack` is high, combinationally, in the cycle in which an idle, ready controller accepts `req_valid`. The ACTIVE appears on the pins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 12 | Row of the request |
| req_col | input | 10 | Column of the request |
| req_ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Controller cannot accept a request |
| ready | output | 1 | Initialisation complete |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed row/column/mode address |

## Verification
The embedded properties watch the command pins on every cycle. Small counters record how many clocks have passed since the last ACTIVE, PRECHARGE, refresh, WRITE and mode load. From these the properties check:
- the power-up wait;
- the row-to-column delay;
- the minimum row-open time and the write-recovery time before PRECHARGE;
- the precharge-to-activate and activate-to-activate spacing;
- the gap after a mode load;
- that an acknowledge is followed by ACTIVE.

Only the bench scenarios show the rest:
- the exact order of the initialisation sequence and the mode word;
- the address and bank multiplexing for each pattern;
- the exact refresh period;
- that a refresh already under way delays a waiting request.

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl #(
  parameter int T_CK_PS   = 7500,
  parameter int CAS_LAT   = 3,
  parameter int INIT_REFS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_bank,
  input  logic [11:0] req_row,
  input  logic [9:0]  req_col,
  output logic        req_ack,
  output logic        busy,
  output logic        ready,
  output logic        sd_cs_n,
  output logic        sd_ras_n,
  output logic        sd_cas_n,
  output logic        sd_we_n,
  output logic [1:0]  sd_ba,
  output logic [11:0] sd_addr
);
  function automatic int cyc(input int ps);
    int c;
    c = (ps + T_CK_PS - 1) / T_CK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int C_RCD     = cyc(20000);
  localparam int C_RP      = cyc(20000);
  localparam int C_RAS     = cyc(45000);
  localparam int C_RC      = cyc(67500);
  localparam int C_DPL     = cyc(8000);
  localparam int C_MRD     = 2;
  localparam int C_PWR     = cyc(100000000);
  localparam int C_REFI    = 15625000 / T_CK_PS;
  localparam int C_RD_REM  = (C_RAS > C_RCD) ? C_RAS - C_RCD : 1;
  localparam int C_WR_REM  = (C_DPL > C_RD_REM) ? C_DPL : C_RD_REM;
  localparam int C_RC_LEFT = C_RC - C_RCD - C_RD_REM;
  localparam int C_PRE_GAP = (C_RC_LEFT > C_RP) ? C_RC_LEFT : C_RP;
  localparam int WW        = $clog2(C_PWR + 1);
  localparam int RW        = $clog2(C_REFI + 1);

  localparam logic [3:0] CMD_NOP = 4'b0111, CMD_ACT = 4'b0011, CMD_RD  = 4'b0101,
                         CMD_WR  = 4'b0100, CMD_PRE = 4'b0010, CMD_REF = 4'b0001,
                         CMD_MRS = 4'b0000;

  typedef enum logic [2:0] {S_PWR, S_PREA, S_REF, S_MRS, S_IDLE, S_ACT, S_RW, S_PRE} state_t;

  state_t          state;
  logic [WW-1:0]   wait_q;
  logic [RW-1:0]   ref_cnt;
  logic            ref_due;
  logic [3:0]      n_ref;
  logic [3:0]      cmd_q;
  logic [1:0]      ba_q, bank_q;
  logic [11:0]     addr_q;
  logic [9:0]      col_q;
  logic            wr_q;

  wire idle_free = ready && state == S_IDLE && !ref_due;
  assign req_ack = idle_free && req_valid;
  assign busy    = !idle_free;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba   = ba_q;
  assign sd_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_PWR;
      wait_q <= WW'(C_PWR - 1);
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      ready  <= 1'b0;
      n_ref  <= '0;
      bank_q <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      if (state != S_IDLE && wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end else begin
        case (state)
          S_PWR: begin
            cmd_q      <= CMD_PRE;
            addr_q[10] <= 1'b1;
            wait_q     <= WW'(C_PRE_GAP - 1);
            state      <= S_PREA;
          end
          S_PREA: begin
            cmd_q  <= CMD_REF;
            wait_q <= WW'(C_RC - 1);
            if (!ready) n_ref <= n_ref + 1'b1;
            state  <= S_REF;
          end
          S_REF: begin
            if (ready) begin
              state <= S_IDLE;
            end else if (n_ref < 4'(INIT_REFS)) begin
              cmd_q  <= CMD_REF;
              wait_q <= WW'(C_RC - 1);
              n_ref  <= n_ref + 1'b1;
            end else begin
              cmd_q  <= CMD_MRS;
              addr_q <= {5'b0, 3'(CAS_LAT), 4'b0000};
              wait_q <= WW'(C_MRD - 1);
              state  <= S_MRS;
            end
          end
          S_MRS: begin
            ready <= 1'b1;
            state <= S_IDLE;
          end
          S_IDLE: begin
            if (ref_due) begin
              cmd_q      <= CMD_PRE;
              addr_q[10] <= 1'b1;
              wait_q     <= WW'(C_PRE_GAP - 1);
              state      <= S_PREA;
            end else if (req_valid) begin
              cmd_q  <= CMD_ACT;
              ba_q   <= req_bank;
              addr_q <= req_row;
              bank_q <= req_bank;
              col_q  <= req_col;
              wr_q   <= req_write;
              wait_q <= WW'(C_RCD - 1);
              state  <= S_ACT;
            end
          end
          S_ACT: begin
            cmd_q  <= wr_q ? CMD_WR : CMD_RD;
            ba_q   <= bank_q;
            addr_q <= {2'b00, col_q};
            wait_q <= wr_q ? WW'(C_WR_REM - 1) : WW'(C_RD_REM - 1);
            state  <= S_RW;
          end
          S_RW: begin
            cmd_q  <= CMD_PRE;
            ba_q   <= bank_q;
            wait_q <= WW'(C_PRE_GAP - 1);
            state  <= S_PRE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      ref_due <= 1'b0;
    end else if (!ready) begin
      ref_cnt <= '0;
      ref_due <= 1'b0;
    end else begin
      if (state == S_PREA && wait_q == '0) ref_due <= 1'b0;
      if (ref_cnt == RW'(C_REFI - 1)) begin
        ref_cnt <= '0;
        ref_due <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end

  wire [3:0] pins   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  wire       is_act = pins == CMD_ACT;
  wire       is_pre = pins == CMD_PRE;
  wire       is_ref = pins == CMD_REF;
  wire       is_wr  = pins == CMD_WR;
  wire       is_rw  = pins == CMD_RD || is_wr;
  wire       is_mrs = pins == CMD_MRS;
  int age, c_act, c_pre, c_rc, c_wr, c_mrs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= 0; c_act <= 1000; c_pre <= 1000; c_rc <= 1000; c_wr <= 1000; c_mrs <= 1000;
    end else begin
      if (age < C_PWR) age <= age + 1;
      c_act <= is_act ? 1 : (c_act < 1000 ? c_act + 1 : c_act);
      c_pre <= is_pre ? 1 : (c_pre < 1000 ? c_pre + 1 : c_pre);
      c_rc  <= (is_act || is_ref) ? 1 : (c_rc < 1000 ? c_rc + 1 : c_rc);
      c_wr  <= is_wr  ? 1 : (c_wr  < 1000 ? c_wr  + 1 : c_wr);
      c_mrs <= is_mrs ? 1 : (c_mrs < 1000 ? c_mrs + 1 : c_mrs);
    end
  end

  p_pwr_wait_r2: assert property (@(posedge clk) disable iff (!rst_n) (pins != CMD_NOP) |-> age >= C_PWR);
  p_ready_gap_r3: assert property (@(posedge clk) disable iff (!rst_n) $rose(ready) |-> c_mrs == C_MRD);
  p_rcd_r4: assert property (@(posedge clk) disable iff (!rst_n) is_rw |-> c_act >= C_RCD);
  p_ras_r5: assert property (@(posedge clk) disable iff (!rst_n) is_pre |-> c_act >= C_RAS);
  p_dpl_r5: assert property (@(posedge clk) disable iff (!rst_n) is_pre |-> c_wr >= C_DPL);
  p_rp_r6: assert property (@(posedge clk) disable iff (!rst_n) (is_act || is_ref) |-> c_pre >= C_RP);
  p_rc_r7: assert property (@(posedge clk) disable iff (!rst_n) (is_act || is_ref) |-> c_rc >= C_RC);
  p_mrd_r8: assert property (@(posedge clk) disable iff (!rst_n) (pins != CMD_NOP && !is_mrs) |-> c_mrs >= C_MRD);
  p_ack_act_r11: assert property (@(posedge clk) disable iff (!rst_n) req_ack |=> is_act);
endmodule

// File: tb/sdram_seq_ctrl_test.sv
module sdram_seq_ctrl_test;
  localparam int TCK = 7500;
  localparam int CL  = 3;
  localparam int E_RCD  = (20000 + TCK - 1) / TCK;
  localparam int E_RP   = (20000 + TCK - 1) / TCK;
  localparam int E_RAS  = (45000 + TCK - 1) / TCK;
  localparam int E_RC   = (67500 + TCK - 1) / TCK;
  localparam int E_DPL  = (8000 + TCK - 1) / TCK;
  localparam int E_PWR  = (100000000 + TCK - 1) / TCK;
  localparam int E_REFI = 15625000 / TCK;
  localparam int E_PRE_R = (E_RAS - E_RCD > 1) ? E_RAS - E_RCD : 1;
  localparam int E_PRE_W = (E_DPL > E_PRE_R) ? E_DPL : E_PRE_R;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
  localparam logic [24:0] VEC [6] = '{
    {1'b1, 2'd0, 12'h000, 10'h000},
    {1'b0, 2'd3, 12'hFFF, 10'h3FF},
    {1'b1, 2'd2, 12'hA5A, 10'h155},
    {1'b0, 2'd1, 12'h123, 10'h2AA},
    {1'b1, 2'd3, 12'h800, 10'h200},
    {1'b0, 2'd0, 12'h7FF, 10'h001}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_bank = 0;
  logic [11:0] req_row = 0;
  logic [9:0] req_col = 0;
  logic req_ack, busy, ready, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [11:0] addr;
  int checks = 0, errors = 0, tick = 0, last_act = -1000, g, t_a, t_b;

  sdram_seq_ctrl #(.T_CK_PS(TCK), .CAS_LAT(CL), .INIT_REFS(2)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_ack(req_ack),
    .busy(busy), .ready(ready), .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n),
    .sd_we_n(we_n), .sd_ba(ba), .sd_addr(addr));

  always #10 clk = ~clk;
  always @(posedge clk) tick++;
  wire [3:0] cmd = {cs_n, ras_n, cas_n, we_n};

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic next_cmd(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (cmd == NOP);
  endtask

  task automatic run_access(input logic [24:0] v);
    int n;
    @(negedge clk);
    {req_write, req_bank, req_row, req_col} = v;
    req_valid = 1;
    #1;
    while (!req_ack) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
    chk(cmd == ACT, "R11 ACT after ack", cmd, ACT);
    chk(ba == v[23:22] && addr == v[21:10], "R4 ACT bank/row", {ba, addr}, v[23:10]);
    chk(tick - last_act >= E_RC, "R7 ACT spacing", tick - last_act, E_RC);
    last_act = tick;
    next_cmd(n);
    chk(n == E_RCD, "R4 ACT to column gap", n, E_RCD);
    chk(cmd == (v[24] ? WR : RD), "R4 column command", cmd, v[24] ? WR : RD);
    chk(ba == v[23:22] && addr == {2'b00, v[9:0]}, "R4 column bank/address", {ba, addr}, {v[23:22], 2'b00, v[9:0]});
    next_cmd(n);
    chk(n == (v[24] ? E_PRE_W : E_PRE_R), "R5 column to PRE gap", n, v[24] ? E_PRE_W : E_PRE_R);
    chk(cmd == PRE && addr[10] == 0 && ba == v[23:22], "R5 single-bank PRE", {cmd, ba, addr[10]}, {PRE, v[23:22], 1'b0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd == NOP && !ready && busy, "R1 reset state", {cmd, ready, busy}, {NOP, 2'b01});
    rst_n = 1;
    #1;
    chk(cmd == NOP && !ready && !req_ack, "R1 after release", {cmd, ready}, {NOP, 1'b0});
    next_cmd(g);
    chk(g == E_PWR, "R2 power-up wait", g, E_PWR);
    chk(cmd == PRE && addr[10], "R2 first is PRECHARGE ALL", {cmd, addr[10]}, {PRE, 1'b1});
    next_cmd(g);
    chk(cmd == REF && g >= E_RP, "R3 first init REF", cmd, REF);
    next_cmd(g);
    chk(cmd == REF && g >= E_RC, "R3 second init REF", cmd, REF);
    next_cmd(g);
    chk(cmd == MRS && ba == 0 && addr == 12'(CL << 4), "R3 mode word", {cmd, ba, addr}, {MRS, 2'b00, 12'(CL << 4)});
    chk(!ready, "R3 ready low at MRS", ready, 0);
    g = 0;
    while (!ready) begin @(negedge clk); g++; end
    chk(g == 2, "R8 ready two clocks after MRS", g, 2);

    foreach (VEC[i]) run_access(VEC[i]);

    next_cmd(g);
    chk(cmd == PRE && addr[10], "R9 refresh preceded by PRE ALL", {cmd, addr[10]}, {PRE, 1'b1});
    next_cmd(g);
    chk(cmd == REF && g >= E_RP, "R6 PRE ALL to REF", g, E_RP);
    t_a = tick;
    next_cmd(g);
    chk(cmd == PRE && addr[10], "R9 second refresh PRE ALL", {cmd, addr[10]}, {PRE, 1'b1});
    {req_write, req_bank, req_row, req_col} = VEC[1];
    req_valid = 1;
    #1;
    chk(busy && !req_ack, "R10 request held during refresh", {busy, req_ack}, 2'b10);
    next_cmd(g);
    t_b = tick;
    chk(cmd == REF, "R10 refresh before request", cmd, REF);
    chk(t_b - t_a == E_REFI, "R9 refresh interval", t_b - t_a, E_REFI);
    next_cmd(g);
    req_valid = 0;
    chk(cmd == ACT && g >= E_RC, "R10 ACT after REF", g, E_RC);
    next_cmd(g);
    chk(cmd == RD, "R10 served read", cmd, RD);
    next_cmd(g);
    chk(cmd == PRE, "R10 served PRE", cmd, PRE);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule